// File: doc/BRIEF.md
# Deep-Sleep Core Rail Controller

This block decides when the system is in its deep-sleep low-power state and tells the core-voltage selector what to do about it. A sleep request pin is qualified by a software enable bit. The block enters sleep only when the AND of the two goes from low to high. Steady high levels never cause entry. While asleep, the block steers the core rail to a preset sleep voltage code. If the core-off configuration bit is set, it asks for the core rail to be switched off instead.

Sleep ends for any of five causes: the request pin falls, the enable bit is cleared, a debounced push-button event arrives, a debounced hot-reset event arrives, or the processor reset is asserted. On exit, the rail goes back to the voltage code that was in use just before entry. This holds even if software changed the normal code while the system slept. Once the block has left sleep, it re-enters only on a fresh rising edge of the qualified request. A push-button event also sets a sticky interrupt flag. A mask bit gates only the interrupt output.

Top module: `lpm_ctrl`

## Requirements
- R1: While `lp_en` is 0, any activity on `lp_req` leaves `lp_active` at 0.
- R2: `lp_active` goes to 1 on the clock edge after a cycle in which `lp_req & lp_en` is 1 and it was 0 in the previous cycle. A level held high since before reset or since the last exit does not cause entry.
- R3: While asleep, a cycle with `lp_req` = 0 or `lp_en` = 0 clears `lp_active` at the next edge.
- R4: A one-cycle `btn_evt` or `hrst_evt` pulse while asleep clears `lp_active` at the next edge. An exit cause wins over a simultaneous entry edge.
- R5: After any exit, `lp_active` stays 0 until a new rising edge of `lp_req & lp_en` occurs. That edge can come from toggling the pin, or from toggling the enable bit while the pin is held high.
- R6: `cpu_rst` = 1 clears `lp_active` at the next edge and blocks entry in that cycle.
- R7: While `lp_active` = 1 and `core_off_cfg` = 0: `sel_sleep` = 1, `core_dis` = 0, and `vcore_code` = `vcore_sleep`. While `lp_active` = 1 and `core_off_cfg` = 1: `core_dis` = 1 and `sel_sleep` = 0. Both outputs are 0 when not asleep.
- R8: Outside sleep, `vcore_code` equals the value `vcore_norm` had one cycle earlier. The normal code is captured in the cycle in which entry is decided. In the first cycle after an exit, `vcore_code` equals that captured code, whatever `vcore_norm` did during sleep.
- R9: `btn_evt` sets a sticky interrupt flag at the next edge. `irq_clr` clears the flag. If both occur in the same cycle, the set wins.
- R10: `irq` = flag AND NOT `irq_mask`. The mask does not change the flag, so clearing the mask exposes an event that arrived while it was masked.
- R11: After reset: `lp_active`, `sel_sleep`, `core_dis` and `irq` are 0, and `vcore_code` equals the parameter `RESET_CODE` (default 6'h24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Sleep request pin level |
| lp_en | input | 1 | Sleep enable register bit |
| core_off_cfg | input | 1 | Switch core off instead of lowering it in sleep |
| btn_evt | input | 1 | Debounced push-button event pulse |
| hrst_evt | input | 1 | Debounced hot-reset event pulse |
| cpu_rst | input | 1 | Processor reset active |
| irq_mask | input | 1 | 1 suppresses the push-button interrupt output |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| vcore_norm | input | CODE_W | Normal core voltage code |
| vcore_sleep | input | CODE_W | Preset sleep core voltage code |
| lp_active | output | 1 | Sleep state active |
| core_dis | output | 1 | Request to disable the core rail |
| sel_sleep | output | 1 | Selects the sleep voltage code |
| vcore_code | output | CODE_W | Voltage code presented to the core regulator |
| irq | output | 1 | Push-button interrupt |

## Verification
The edge-history register is the state most likely to go wrong. If it is wrong, the block either re-enters sleep right after a push-button exit while the pin is still high, or it fails to enter on a genuine toggle. Either way, `lp_active` shows the error one edge after the offending cycle. A wrong capture register shows only at exit, in the very first cycle of `vcore_code` after `lp_active` falls. For that reason the bench changes `vcore_norm` during sleep and samples that exact cycle. A flag/mask mix-up shows when the mask is released after a masked event.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic {
        LPM_RUN   = 1'b0,
        LPM_SLEEP = 1'b1
    } lpm_state_e;

    // Reasons to leave the sleep state
    typedef struct packed {
        logic req_low;
        logic en_low;
        logic button;
        logic hot_reset;
        logic cpu_reset;
    } lpm_exit_t;

    function automatic logic lpm_any_exit(input lpm_exit_t e);
        return e.req_low | e.en_low | e.button | e.hot_reset | e.cpu_reset;
    endfunction

    // Only these causes can coincide with a rising qualified request
    function automatic logic lpm_blocks_entry(input lpm_exit_t e);
        return e.button | e.hot_reset | e.cpu_reset;
    endfunction

endpackage

// File: rtl/lpm_entry_det.sv
module lpm_entry_det (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic en,
    output logic qual,
    output logic rise
);
    logic qual_q;

    assign qual = req & en;

    always_ff @(posedge clk) begin
        if (rst) qual_q <= 1'b1;   // a level high out of reset is not an edge
        else     qual_q <= qual;
    end

    assign rise = qual & ~qual_q;
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  lpm_exit_t  exits,
    output lpm_state_e state
);
    lpm_state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            LPM_RUN: begin
                if (rise && !lpm_blocks_entry(exits)) state_n = LPM_SLEEP;
            end
            LPM_SLEEP: begin
                if (lpm_any_exit(exits)) state_n = LPM_RUN;
            end
            default: state_n = LPM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LPM_RUN;
        else     state <= state_n;
    end
endmodule

// File: rtl/lpm_vsel.sv
module lpm_vsel #(
    parameter int              CODE_W     = 6,
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              asleep,
    input  logic              core_off,
    input  logic [CODE_W-1:0] norm_code,
    input  logic [CODE_W-1:0] sleep_code,
    output logic [CODE_W-1:0] code,
    output logic              use_sleep,
    output logic              rail_off
);
    logic [CODE_W-1:0] held_q;

    // Tracks the normal code while awake, freezes during sleep
    always_ff @(posedge clk) begin
        if (rst)          held_q <= RESET_CODE;
        else if (!asleep) held_q <= norm_code;
    end

    assign use_sleep = asleep & ~core_off;
    assign rail_off  = asleep &  core_off;
    assign code      = use_sleep ? sleep_code : held_q;
endmodule

// File: rtl/lpm_irq.sv
module lpm_irq (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    input  logic mask,
    output logic irq
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (evt) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & ~mask;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int                CODE_W     = 6,
    parameter logic [CODE_W-1:0] RESET_CODE = 6'h24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_req,
    input  logic              lp_en,
    input  logic              core_off_cfg,
    input  logic              btn_evt,
    input  logic              hrst_evt,
    input  logic              cpu_rst,
    input  logic              irq_mask,
    input  logic              irq_clr,
    input  logic [CODE_W-1:0] vcore_norm,
    input  logic [CODE_W-1:0] vcore_sleep,
    output logic              lp_active,
    output logic              core_dis,
    output logic              sel_sleep,
    output logic [CODE_W-1:0] vcore_code,
    output logic              irq
);
    logic       qual;
    logic       rise;
    lpm_exit_t  exits;
    lpm_state_e state;

    lpm_entry_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .req  (lp_req),
        .en   (lp_en),
        .qual (qual),
        .rise (rise)
    );

    always_comb begin
        exits.req_low   = ~lp_req;
        exits.en_low    = ~lp_en;
        exits.button    = btn_evt;
        exits.hot_reset = hrst_evt;
        exits.cpu_reset = cpu_rst;
    end

    lpm_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .rise  (rise),
        .exits (exits),
        .state (state)
    );

    assign lp_active = (state == LPM_SLEEP);

    lpm_vsel #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_vsel (
        .clk        (clk),
        .rst        (rst),
        .asleep     (lp_active),
        .core_off   (core_off_cfg),
        .norm_code  (vcore_norm),
        .sleep_code (vcore_sleep),
        .code       (vcore_code),
        .use_sleep  (sel_sleep),
        .rail_off   (core_dis)
    );

    lpm_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .evt  (btn_evt),
        .clr  (irq_clr),
        .mask (irq_mask),
        .irq  (irq)
    );

    logic unused_qual;
    assign unused_qual = qual;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic lp_req,
    input logic lp_en,
    input logic core_off_cfg,
    input logic btn_evt,
    input logic hrst_evt,
    input logic cpu_rst,
    input logic irq_mask,
    input logic lp_active,
    input logic core_dis,
    input logic sel_sleep,
    input logic irq
);
    AST_NO_ENTRY_WITHOUT_EN: assert property (@(posedge clk) disable iff (rst)
        !lp_en |=> !lp_active);                                      // R1
    AST_ENTRY_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (!lp_active && !(lp_req && lp_en)) |=> !lp_active);          // R2
    AST_EXIT_ON_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
        !lp_req |=> !lp_active);                                     // R3
    AST_EXIT_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        (btn_evt || hrst_evt) |=> !lp_active);                       // R4
    AST_NO_REENTRY_ON_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!lp_active && lp_req && lp_en && $past(lp_req && lp_en)) |=> !lp_active); // R5
    AST_CPU_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
        cpu_rst |=> !lp_active);                                     // R6
    AST_RAIL_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (core_dis || sel_sleep) |-> (lp_active && (core_dis == core_off_cfg))); // R7
    AST_BTN_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        btn_evt |=> (irq || irq_mask));                              // R9
    AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq_mask |-> !irq);                                          // R10
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .lp_req       (lp_req),
    .lp_en        (lp_en),
    .core_off_cfg (core_off_cfg),
    .btn_evt      (btn_evt),
    .hrst_evt     (hrst_evt),
    .cpu_rst      (cpu_rst),
    .irq_mask     (irq_mask),
    .lp_active    (lp_active),
    .core_dis     (core_dis),
    .sel_sleep    (sel_sleep),
    .irq          (irq)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
    localparam int CW = 6;
    localparam logic [CW-1:0] RC = 6'h24;

    logic clk = 1'b0;
    logic rst;
    logic lp_req, lp_en, core_off_cfg, btn_evt, hrst_evt, cpu_rst, irq_mask, irq_clr;
    logic [CW-1:0] vcore_norm, vcore_sleep, vcore_code;
    logic lp_active, core_dis, sel_sleep, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench reference state
    bit m_prev, m_lp, m_flag;
    logic [CW-1:0] m_saved;

    always #5 clk = ~clk;

    lpm_ctrl #(.CODE_W(CW), .RESET_CODE(RC)) u_dut (.*);

    function automatic logic [CW-1:0] exp_code();
        return (m_lp && !core_off_cfg) ? vcore_sleep : m_saved;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "lp_active", 32'(lp_active), 32'(m_lp));
        chk(tag, "sel_sleep", 32'(sel_sleep), 32'(m_lp & ~core_off_cfg));
        chk(tag, "core_dis",  32'(core_dis),  32'(m_lp & core_off_cfg));
        chk(tag, "vcore_code", 32'(vcore_code), 32'(exp_code()));
        chk(tag, "irq", 32'(irq), 32'(m_flag & ~irq_mask));
    endtask

    // advance one clock with the inputs currently driven, then compare
    task automatic step(input string tag);
        bit q, rise, ex, n_lp, n_flag;
        logic [CW-1:0] n_saved;
        q    = lp_req & lp_en;
        rise = q & ~m_prev;
        ex   = ~lp_req | ~lp_en | btn_evt | hrst_evt | cpu_rst;
        n_lp = ex ? 1'b0 : (rise ? 1'b1 : m_lp);
        n_saved = m_lp ? m_saved : vcore_norm;
        n_flag = btn_evt ? 1'b1 : (irq_clr ? 1'b0 : m_flag);
        @(posedge clk);
        m_prev = q; m_lp = n_lp; m_saved = n_saved; m_flag = n_flag;
        @(negedge clk);
        check_all(tag);
        btn_evt = 0; hrst_evt = 0; cpu_rst = 0; irq_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A5EED));
        rst = 1; lp_req = 0; lp_en = 0; core_off_cfg = 0; btn_evt = 0; hrst_evt = 0;
        cpu_rst = 0; irq_mask = 0; irq_clr = 0; vcore_norm = 6'h1A; vcore_sleep = 6'h08;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_prev = 1; m_lp = 0; m_flag = 0; m_saved = RC;
        // R11 reset state
        chk("R11", "lp_active", 32'(lp_active), 0);
        chk("R11", "irq", 32'(irq), 0);
        chk("R11", "core_dis", 32'(core_dis), 0);
        chk("R11", "vcore_code", 32'(vcore_code), 32'(RC));
        rst = 0;
        step("R11");

        // R1 pin toggles without enable
        for (int i = 0; i < 4; i++) begin lp_req = ~lp_req; step("R1"); end
        chk("R1", "lp_active held low", 32'(lp_active), 0);

        // R2 entry on edge via enable with pin high
        lp_req = 1; step("R2");
        lp_en = 1; step("R2");
        chk("R2", "entered", 32'(lp_active), 1);
        // R7 sleep code selected
        chk("R7", "sleep code", 32'(vcore_code), 32'(6'h08));
        core_off_cfg = 1; step("R7");
        chk("R7", "core off", 32'(core_dis), 1);
        core_off_cfg = 0;
        // R8 change normal code during sleep, then exit and see pre-entry code
        vcore_norm = 6'h05; step("R8"); step("R8");
        lp_req = 0; step("R8");
        chk("R8", "restored code", 32'(vcore_code), 32'(6'h1A));
        step("R8");
        chk("R8", "tracking resumes", 32'(vcore_code), 32'(6'h05));
        // R3 exit on enable low
        lp_req = 1; step("R3");
        chk("R3", "re-entered by pin", 32'(lp_active), 1);
        lp_en = 0; step("R3");
        chk("R3", "exit on enable low", 32'(lp_active), 0);
        // R5 enable toggle while pin high re-enters
        lp_en = 1; step("R5");
        chk("R5", "re-entry via enable", 32'(lp_active), 1);
        // R4 push-button exit, no re-entry on held level
        btn_evt = 1; step("R4");
        chk("R4", "button exit", 32'(lp_active), 0);
        step("R5"); step("R5");
        chk("R5", "no re-entry on level", 32'(lp_active), 0);
        // R9 flag sticky, R10 mask
        chk("R9", "irq set", 32'(irq), 1);
        irq_mask = 1; step("R10");
        chk("R10", "masked", 32'(irq), 0);
        irq_mask = 0; step("R10");
        chk("R10", "flag kept under mask", 32'(irq), 1);
        irq_clr = 1; btn_evt = 1; step("R9");
        chk("R9", "set beats clear", 32'(irq), 1);
        irq_clr = 1; step("R9");
        chk("R9", "cleared", 32'(irq), 0);
        // R4 hot reset exit; entry blocked by simultaneous event
        lp_req = 0; step("R4");
        lp_req = 1; hrst_evt = 1; step("R4");
        chk("R4", "event blocks entry", 32'(lp_active), 0);
        lp_req = 0; step("R4"); lp_req = 1; step("R4");
        hrst_evt = 1; step("R4");
        chk("R4", "hot reset exit", 32'(lp_active), 0);
        // R6 cpu reset exit
        lp_req = 0; step("R6"); lp_req = 1; step("R6");
        cpu_rst = 1; step("R6");
        chk("R6", "cpu reset exit", 32'(lp_active), 0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(99) < 30) lp_req = ~lp_req;
            if ($urandom_range(99) < 10) lp_en = ~lp_en;
            if ($urandom_range(99) < 10) core_off_cfg = ~core_off_cfg;
            if ($urandom_range(99) < 15) irq_mask = ~irq_mask;
            btn_evt  = ($urandom_range(99) < 5);
            hrst_evt = ($urandom_range(99) < 4);
            cpu_rst  = ($urandom_range(99) < 3);
            irq_clr  = ($urandom_range(99) < 8);
            if ($urandom_range(99) < 20) vcore_norm = CW'($urandom);
            if ($urandom_range(99) < 5)  vcore_sleep = CW'($urandom);
            step("R2/R3/R8 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule